// File: doc/BRIEF.md
# Biphase-Checked IR Frame Receiver

This block takes a demodulated infrared line, where a high level is a pulse and a low level is a space. It recovers one 31-bit scancode per frame. A one-microsecond tick strobe times the line. The block measures how long each level lasts and cuts every run into whole time units, rounding to the nearest unit. It then walks a slot state machine over those units. A frame is a single-unit pulse header followed by 31 bits. Each bit has two slots: a check slot, then a data slot. The data bits arrive most significant first.

At a fixed set of bit positions the check slot is redundant: it carries a pulse exactly when the current data bit and the one before it are both zero. At every other position the check slot must be a space. Any breach of the slot rules raises a one-cycle error strobe. The receiver then stays deaf until the line has shown a long, fresh space. A clean frame ends with a space unit after the last data bit. That unit loads the scancode output and fires a one-cycle valid strobe.

Top module: `ir_frame_rx`

## Requirements
- R1: A run of d microseconds at one level yields floor((d + HALF_US) / UNIT_US) units, where HALF_US = UNIT_US/2. Each unit is issued while the run is still in progress, once d reaches HALF_US + k*UNIT_US.
- R2: In the idle state, space units are ignored. A pulse unit is the header: it starts a frame, clears the shift register and sets the bit index to 30.
- R3: After the header come 31 slot pairs for bit indices 30 down to 0: first a check slot, then a data slot. In a data slot, space means 1 and pulse means 0. The bit is shifted in at the LSB, so scancode[30] is the first data bit received.
- R4: At a bit index whose CHK_MASK bit is 0, a pulse in the check slot raises the error strobe.
- R5: At a bit index i whose CHK_MASK bit is 1 (default mask 31'h437F7E00: indices 9 to 14, 16 to 22, 24, 25 and 30), the check slot must be a pulse exactly when data bits i and i+1 are both 0, with bit 31 taken as 0. Otherwise the error strobe is raised at the data slot.
- R6: After data bit 0, a space unit loads scancode and pulses frame_valid. A pulse unit at that point raises the error strobe.
- R7: After an error, every unit is ignored. The receiver returns to idle only when a space run that began after the error exceeds GAP_US microseconds.
- R8: frame_valid and frame_error are strobes one cycle wide and never active together. The scancode output changes only in a cycle where frame_valid is high.
- R9: The run-length counter saturates at GAP_US+1 and does not wrap, however long a space lasts.
- R10: Reset forces the idle state, a zero scancode and both strobes low. A frame cut off by reset leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle strobe each microsecond |
| ir_line | input | 1 | Demodulated line, 1 = pulse, 0 = space |
| scancode | output | 31 | Last decoded scancode, held between frames |
| frame_valid | output | 1 | One-cycle strobe: a new scancode is on the output |
| frame_error | output | 1 | One-cycle strobe: the frame broke a slot rule |

## Verification
Several rules are checked on every cycle by the assertions:
- units appear only on a tick and never on an edge cycle;
- the unit phase and run counter stay in range, and the run counter stays saturated;
- idle ignores spaces, and a pulse in a check slot at a non-check index leads to an error;
- the error state is sticky, and a valid strobe comes only from the finished state;
- the two strobes are exclusive, and the scancode moves only on a valid strobe.

Other behaviour shows only in the bench's frame scenarios:
- rounding of runs stretched or shortened by nearly half a unit;
- check-slot mismatches in both directions;
- the trailing pulse after the last bit;
- deafness after an error, including a long space that started before the error;
- a glitch too short to count, and a reset in mid-frame.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CHK  = 3'd1,
    ST_DAT  = 3'd2,
    ST_DONE = 3'd3,
    ST_ERR  = 3'd4
  } rx_state_e;

  // Data slot: a space carries a one, a pulse carries a zero.
  function automatic logic slot_to_bit(input logic lvl);
    return ~lvl;
  endfunction

  // A check slot owes a pulse when the newest two bits are both zero.
  function automatic logic check_wants_pulse(input logic [1:0] newest_two);
    return (newest_two == 2'b00);
  endfunction

endpackage

// File: rtl/ir_run_meter.sv
module ir_run_meter #(
  parameter int UNIT_US = 416,
  parameter int HALF_US = 208,
  parameter int GAP_US  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic line_i,
  output logic run_edge_o,
  output logic unit_stb_o,
  output logic unit_lvl_o,
  output logic long_space_o
);

  localparam int PH_W    = $clog2(UNIT_US + 1);
  localparam int RUN_SAT = GAP_US + 1;
  localparam int RUN_W   = $clog2(RUN_SAT + 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(UNIT_US - 1);
  localparam logic [PH_W-1:0]  PH_START = PH_W'(UNIT_US - HALF_US);
  localparam logic [RUN_W-1:0] RUN_TOP  = RUN_W'(RUN_SAT);

  logic             level_q;
  logic [PH_W-1:0]  phase_q;
  logic [RUN_W-1:0] run_q;

  // Named internal events
  logic edge_seen;
  logic unit_due;
  logic run_full;

  assign edge_seen = (line_i != level_q);
  assign unit_due  = us_tick && !edge_seen && (phase_q == PH_LAST);
  assign run_full  = (run_q == RUN_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      phase_q <= PH_START;
      run_q   <= '0;
    end else if (edge_seen) begin
      level_q <= line_i;
      phase_q <= PH_START + PH_W'(us_tick);
      run_q   <= RUN_W'(us_tick);
    end else if (us_tick) begin
      phase_q <= unit_due ? '0 : phase_q + 1'b1;
      if (!run_full) run_q <= run_q + 1'b1;
    end
  end

  assign run_edge_o   = edge_seen;
  assign unit_stb_o   = unit_due;
  assign unit_lvl_o   = level_q;
  assign long_space_o = !level_q && run_full;

  AST_UNIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    unit_stb_o |-> (us_tick && !run_edge_o)); // R1
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PH_LAST); // R1
  AST_RUN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_TOP); // R9
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_full && !run_edge_o) |=> run_full); // R9

endmodule

// File: rtl/ir_slot_decoder.sv
module ir_slot_decoder
  import ir_rx_pkg::*;
#(
  parameter int               NBITS    = 31,
  parameter logic [NBITS-1:0] CHK_MASK = 31'h437F7E00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_stb,
  input  logic             unit_lvl,
  input  logic             run_edge,
  input  logic             long_space,
  output logic [NBITS-1:0] code_o,
  output logic             valid_o,
  output logic             error_o
);

  localparam int CNT_W = $clog2(NBITS);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(NBITS - 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NBITS-1:0] shreg_q, shreg_d;
  logic             chk_q, chk_d;
  logic             tainted_q;

  // Named internal events
  logic             go_err;
  logic             go_valid;
  logic             recover;
  logic             chk_pos;
  logic [NBITS-1:0] shifted;

  assign chk_pos = CHK_MASK[cnt_q];
  assign shifted = {shreg_q[NBITS-2:0], slot_to_bit(unit_lvl)};
  assign recover = (state_q == ST_ERR) && long_space && !tainted_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    chk_d    = chk_q;
    go_err   = 1'b0;
    go_valid = 1'b0;
    if (recover) begin
      state_d = ST_IDLE;
    end else if (unit_stb) begin
      unique case (state_q)
        ST_IDLE: if (unit_lvl) begin
          state_d = ST_CHK;
          cnt_d   = CNT_TOP;
          shreg_d = '0;
        end
        ST_CHK: begin
          if (!chk_pos && unit_lvl) begin
            go_err = 1'b1;
          end else begin
            if (chk_pos) chk_d = unit_lvl;
            state_d = ST_DAT;
          end
        end
        ST_DAT: begin
          shreg_d = shifted;
          if (chk_pos && (chk_q != check_wants_pulse(shifted[1:0]))) begin
            go_err = 1'b1;
          end else if (cnt_q == '0) begin
            state_d = ST_DONE;
          end else begin
            cnt_d   = cnt_q - 1'b1;
            state_d = ST_CHK;
          end
        end
        ST_DONE: begin
          if (unit_lvl) begin
            go_err = 1'b1;
          end else begin
            go_valid = 1'b1;
            state_d  = ST_IDLE;
          end
        end
        default: ;
      endcase
      if (go_err) state_d = ST_ERR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      chk_q     <= 1'b0;
      tainted_q <= 1'b0;
      code_o    <= '0;
      valid_o   <= 1'b0;
      error_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      chk_q   <= chk_d;
      valid_o <= go_valid;
      error_o <= go_err;
      if (go_valid) code_o <= shreg_q;
      if (go_err) tainted_q <= 1'b1;
      else if (run_edge) tainted_q <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP); // R3
  AST_IDLE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && unit_stb && !unit_lvl) |=> state_q == ST_IDLE); // R2
  AST_NONCHK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHK && unit_stb && unit_lvl && !chk_pos) |=> error_o); // R4
  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(state_q) == ST_DONE); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERR && !(long_space && !tainted_q)) |=> state_q == ST_ERR); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({valid_o, error_o})); // R8
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != $past(code_o)) |-> valid_o); // R8

endmodule

// File: rtl/ir_frame_rx.sv
module ir_frame_rx #(
  parameter int               UNIT_US  = 416,
  parameter int               GAP_US   = 10000,
  parameter int               NBITS    = 31,
  parameter logic [NBITS-1:0] CHK_MASK = 31'h437F7E00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             ir_line,
  output logic [NBITS-1:0] scancode,
  output logic             frame_valid,
  output logic             frame_error
);

  localparam int HALF_US = UNIT_US / 2;

  logic run_edge;
  logic unit_stb;
  logic unit_lvl;
  logic long_space;

  ir_run_meter #(
    .UNIT_US (UNIT_US),
    .HALF_US (HALF_US),
    .GAP_US  (GAP_US)
  ) u_meter (
    .clk          (clk),
    .rst_n        (rst_n),
    .us_tick      (us_tick),
    .line_i       (ir_line),
    .run_edge_o   (run_edge),
    .unit_stb_o   (unit_stb),
    .unit_lvl_o   (unit_lvl),
    .long_space_o (long_space)
  );

  ir_slot_decoder #(
    .NBITS    (NBITS),
    .CHK_MASK (CHK_MASK)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .unit_stb   (unit_stb),
    .unit_lvl   (unit_lvl),
    .run_edge   (run_edge),
    .long_space (long_space),
    .code_o     (scancode),
    .valid_o    (frame_valid),
    .error_o    (frame_error)
  );

  AST_STROBE_NO_RESET_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!frame_valid && !frame_error)); // R10

endmodule

// File: tb/tb_ir_frame_rx.sv
module tb_ir_frame_rx;

  localparam int U    = 16;
  localparam int H    = U / 2;
  localparam int GAP  = 400;
  localparam int TAIL = 500;
  localparam logic [30:0] CMASK = 31'h437F7E00;

  // {scancode[30:0], adjust mode[1:0]}: 0 exact, 1 stretched by H-1, 2 shortened by H
  localparam logic [32:0] VEC [10] = '{
    {31'h0000_0000, 2'd0}, {31'h7FFF_FFFF, 2'd0}, {31'h155A_A5A5, 2'd0},
    {31'h1234_5678, 2'd1}, {31'h0000_0001, 2'd2}, {31'h4000_0000, 2'd1},
    {31'h2991_15B7, 2'd0}, {31'h3C3C_0F0F, 2'd2}, {31'h6AAA_5555, 2'd1},
    {31'h0F0F_F0F0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        ir_line = 1'b0;
  logic [30:0] scancode;
  logic        frame_valid;
  logic        frame_error;

  int checks = 0;
  int errors = 0;
  int n_valid = 0;
  int n_err = 0;
  int n_wide = 0;
  logic [30:0] got_code = '0;
  logic prev_valid = 1'b0;
  logic prev_err = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) us_tick <= ~us_tick;

  ir_frame_rx #(.UNIT_US(U), .GAP_US(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ir_line(ir_line),
    .scancode(scancode), .frame_valid(frame_valid), .frame_error(frame_error)
  );

  always @(negedge clk) begin
    if (frame_valid) begin n_valid++; got_code = scancode; end
    if (frame_error) n_err++;
    if ((frame_valid && prev_valid) || (frame_error && prev_err) ||
        (frame_valid && frame_error)) n_wide++;
    prev_valid = frame_valid;
    prev_err   = frame_error;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int t);
    repeat (2 * t) @(negedge clk);
  endtask

  task automatic drive(input logic lvl, input int t);
    ir_line = lvl;
    wait_ticks(t);
  endtask

  // Slot 0 = header; check slot of bit i = 1+2*(30-i); data slot = 2+2*(30-i); slot 63 = extra pulse
  task automatic send_frame(input logic [30:0] c, input int adj, input int flip,
                            input int nslots, input bit tpulse, input int tail);
    logic lv [64];
    int n;
    int k;
    lv[0] = 1'b1;
    for (int i = 30; i >= 0; i--) begin
      lv[1 + 2*(30-i)] = CMASK[i] ? !(c[i] | ((i == 30) ? 1'b0 : c[(i == 30) ? 0 : i+1])) : 1'b0;
      lv[2 + 2*(30-i)] = !c[i];
    end
    lv[63] = 1'b1;
    n = tpulse ? 64 : nslots;
    if (flip >= 0) lv[flip] = !lv[flip];
    k = 1;
    for (int s = 1; s <= n; s++) begin
      if (s == n || lv[s] != lv[s-1]) begin
        drive(lv[s-1], k*U + adj);
        k = 1;
      end else begin
        k++;
      end
    end
    drive(1'b0, tail);
  endtask

  task automatic expect_frame(input string req, input int v0, input int e0,
                              input int dv, input int de, input logic [30:0] code);
    check(n_valid - v0 == dv, req, 32'(n_valid - v0), 32'(dv));
    check(n_err - e0 == de, req, 32'(n_err - e0), 32'(de));
    if (dv > 0) check(got_code == code, req, {1'b0, got_code}, {1'b0, code});
    check(scancode == code, {req, " hold"}, {1'b0, scancode}, {1'b0, code});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v0;
    int e0;
    logic [30:0] last;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(scancode == '0, "R10 code", {1'b0, scancode}, 32'd0);
    check(!frame_valid && !frame_error, "R10 strobes", {30'd0, frame_valid, frame_error}, 32'd0);
    rst_n = 1'b1;
    wait_ticks(20);

    // R1 R3 R5 R6: vector table, exact and rounded timing
    for (int v = 0; v < 10; v++) begin
      int adj;
      adj = (VEC[v][1:0] == 2'd1) ? (H - 1) : (VEC[v][1:0] == 2'd2) ? -H : 0;
      v0 = n_valid; e0 = n_err;
      send_frame(VEC[v][32:2], adj, -1, 63, 1'b0, TAIL);
      expect_frame("R1 R3 vector", v0, e0, 1, 0, VEC[v][32:2]);
    end
    last = VEC[9][32:2];

    // R4: pulse in check slot of non-check bit 29
    v0 = n_valid; e0 = n_err;
    send_frame(31'h0123_4567, 0, 3, 63, 1'b0, TAIL);
    expect_frame("R4 nonchk pulse", v0, e0, 0, 1, last);

    // R5: check slot of bit 30 should be pulse (bits 31,30 zero), sent as space
    v0 = n_valid; e0 = n_err;
    send_frame(31'h0123_4567, 0, 1, 63, 1'b0, TAIL);
    expect_frame("R5 missing chk pulse", v0, e0, 0, 1, last);

    // R5: bits 10,9 = 1,0 so check slot of bit 9 must be space; sent as pulse
    v0 = n_valid; e0 = n_err;
    send_frame(31'h0000_0400, 0, 1 + 2*21, 63, 1'b0, TAIL);
    expect_frame("R5 extra chk pulse", v0, e0, 0, 1, last);

    // R6: pulse unit after last data bit
    v0 = n_valid; e0 = n_err;
    send_frame(31'h1234_5678, 0, -1, 63, 1'b1, TAIL);
    expect_frame("R6 trailing pulse", v0, e0, 0, 1, last);

    // R7: error, short gap, clean frame ignored; then recovery
    v0 = n_valid; e0 = n_err;
    send_frame(31'h0123_4567, 0, 3, 63, 1'b0, 2*U);
    send_frame(31'h0555_0AAA, 0, -1, 63, 1'b0, TAIL);
    expect_frame("R7 ignored after err", v0, e0, 0, 1, last);
    v0 = n_valid; e0 = n_err;
    send_frame(31'h0555_0AAA, 0, -1, 63, 1'b0, TAIL);
    expect_frame("R7 recovered", v0, e0, 1, 0, 31'h0555_0AAA);
    last = 31'h0555_0AAA;

    // R7: error raised inside a space that then lasts beyond GAP does not recover
    v0 = n_valid; e0 = n_err;
    send_frame(31'h0200_0000, 0, 1 + 2*5, 13, 1'b0, TAIL);
    send_frame(31'h0777_1111, 0, -1, 63, 1'b0, TAIL);
    expect_frame("R7 tainted space", v0, e0, 0, 1, last);
    v0 = n_valid; e0 = n_err;
    send_frame(31'h0777_1111, 0, -1, 63, 1'b0, TAIL);
    expect_frame("R7 after fresh space", v0, e0, 1, 0, 31'h0777_1111);
    last = 31'h0777_1111;

    // R1 R2: glitch shorter than half a unit is no header
    v0 = n_valid; e0 = n_err;
    drive(1'b1, H - 1);
    drive(1'b0, 3*U);
    send_frame(31'h2468_ACE0, 0, -1, 63, 1'b0, TAIL);
    expect_frame("R2 glitch ignored", v0, e0, 1, 0, 31'h2468_ACE0);
    last = 31'h2468_ACE0;

    // R10: reset mid-frame, then a clean frame
    send_frame(31'h1111_2222, 0, -1, 20, 1'b0, 0);
    ir_line = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(scancode == '0, "R10 mid-frame reset", {1'b0, scancode}, 32'd0);
    rst_n = 1'b1;
    wait_ticks(20);
    v0 = n_valid; e0 = n_err;
    send_frame(31'h3333_4444, 0, -1, 63, 1'b0, TAIL);
    expect_frame("R10 after reset", v0, e0, 1, 0, 31'h3333_4444);

    // R9: very long space, then a clean frame
    v0 = n_valid; e0 = n_err;
    drive(1'b0, 3*GAP);
    send_frame(31'h7000_0007, 0, -1, 63, 1'b0, TAIL);
    expect_frame("R9 long idle", v0, e0, 1, 0, 31'h7000_0007);

    // R8: strobe width
    check(n_wide == 0, "R8 strobe width", 32'(n_wide), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule